// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Entry and Return

This block is a small multicycle processor built around a single accumulator. It reads 16-bit instruction words from a synchronous, word-addressed memory. The upper nibble of each word selects the operation, and the lower twelve bits give a direct operand address. It can load the accumulator, store it and add a memory word to it. Data words use sign-magnitude form, and additions follow sign-magnitude rules. A sticky flag records any magnitude overflow.

Every instruction passes through fetch, latch and execute phases. Loads and adds take one further read phase. Each instruction then ends with an interrupt-check phase, in which the core samples a level-sensitive request line. If a request is present and interrupts are enabled, the core saves the return address and the accumulator into one shadow pair. It then clears the enable flag, jumps to a fixed handler address and raises a one-cycle acknowledge. A return opcode restores the saved pair and enables interrupts again.

The memory port has a fixed latency of one cycle: read data appears in the cycle after the address, and a write completes at the edge where the write enable is high. It is therefore a plain port with no valid/ready handshake and no back-pressure. The request and acknowledge pins and the overflow flag are plain level signals.

Top module: `acc_core`

## Requirements
- R1: During reset and in the first cycle after reset is released, the memory address equals the reset PC (default 0x000, parameter), the write enable is low, the acknowledge is low and the overflow flag is low.
- R2: Bits 15:12 of an instruction are the opcode and bits 11:0 are the operand address. Fetches advance the PC by one for each instruction unless a return or an interrupt entry overrides it.
- R3: Opcode 0x1 copies the memory word at the operand address into the accumulator unchanged.
- R4: Opcode 0x2 writes the accumulator to the operand address with a single-cycle write enable.
- R5: Opcode 0x5 with operands of equal sign (bit 15 is the sign, 1 meaning negative; bits 14:0 are the magnitude) adds the magnitudes and keeps the common sign. The magnitude wraps modulo 2^15.
- R6: Opcode 0x5 with operands of differing sign subtracts the smaller magnitude from the larger and takes the sign of the larger. A zero result is always written as 0x0000.
- R7: An addition whose true magnitude exceeds 0x7FFF sets the overflow flag. The flag stays set until reset.
- R8: Opcodes other than 0x1, 0x2, 0x5 and 0xF change neither the accumulator nor memory, and they issue no write.
- R9: In the check phase after an instruction, a high request with interrupts enabled saves the return PC and the accumulator. The core then fetches next from 0xF00 (parameter), and the acknowledge is high for exactly one cycle, the cycle of that fetch.
- R10: After interrupt entry, the enable flag is clear, so a request that stays high is not taken again until a return.
- R11: Opcode 0xF restores the saved PC and accumulator and enables interrupts again.
- R12: With PC starting at 0x300, the program 0x1940, 0x5941, 0x2941, and data words 0x0003 at 0x940 and 0x0002 at 0x941, memory 0x941 ends at 0x0005 and the next instruction fetched is at 0x303.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address for fetch, read or write |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_we | output | 1 | Write enable, one cycle per store |
| mem_rdata | input | 16 | Read data, valid the cycle after the address |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | One-cycle pulse on interrupt entry |
| ovf | output | 1 | Sticky magnitude-overflow flag |

## Verification
Four properties are checked on every cycle: the acknowledge lasts one cycle, follows a request and coincides with a fetch from the handler address; a masked request is never acknowledged; each store asserts the write enable for one cycle only; and the overflow flag never falls. The arithmetic results can only be shown by the bench's scenarios, which sweep all pairs from a set of corner sign-magnitude values. The scenarios also show the sequential flow of the example program, the inert undefined opcodes, and the restoration of the accumulator and the enable flag after a return.

// File: rtl/accp_pkg.sv
package accp_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_RETI  = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_LATCH,
    PH_EXEC,
    PH_READ,
    PH_IRQ
  } phase_e;
endpackage

// File: rtl/acc_sm_adder.sv
module acc_sm_adder #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MAG_W = DATA_W - 1;

  logic              a_neg, b_neg, res_neg;
  logic [MAG_W-1:0]  a_mag, b_mag, res_mag;
  logic [MAG_W:0]    wide;

  always_comb begin
    a_neg = a[DATA_W-1];
    b_neg = b[DATA_W-1];
    a_mag = a[MAG_W-1:0];
    b_mag = b[MAG_W-1:0];
    ovf   = 1'b0;
    if (a_neg == b_neg) begin
      wide    = {1'b0, a_mag} + {1'b0, b_mag};
      res_neg = a_neg;
      ovf     = wide[MAG_W];
    end else if (a_mag >= b_mag) begin
      wide    = {1'b0, a_mag} - {1'b0, b_mag};
      res_neg = a_neg;
    end else begin
      wide    = {1'b0, b_mag} - {1'b0, a_mag};
      res_neg = b_neg;
    end
    res_mag = wide[MAG_W-1:0];
    if (res_mag == '0) res_neg = 1'b0;
    sum = {res_neg, res_mag};
  end
endmodule

// File: rtl/acc_accu.sv
module acc_accu #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              add_en,
  input  logic              restore_en,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] restore_val,
  output logic [DATA_W-1:0] acc,
  output logic              ovf
);
  logic [DATA_W-1:0] add_res;
  logic              add_ovf;

  acc_sm_adder #(.DATA_W(DATA_W)) adder_i (
    .a   (acc),
    .b   (operand),
    .sum (add_res),
    .ovf (add_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (restore_en) begin
      acc <= restore_val;
    end else if (ld_en) begin
      acc <= operand;
    end else if (add_en) begin
      acc <= add_res;
      if (add_ovf) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_ctx.sv
module acc_ctx #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ret,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              ie,
  output logic [ADDR_W-1:0] sv_pc,
  output logic [DATA_W-1:0] sv_acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie     <= 1'b1;
      sv_pc  <= '0;
      sv_acc <= '0;
    end else if (take) begin
      ie     <= 1'b0;
      sv_pc  <= pc_in;
      sv_acc <= acc_in;
    end else if (ret) begin
      ie     <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import accp_pkg::*;
#(
  parameter int                 ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]  RESET_PC   = '0,
  parameter logic [ADDR_W-1:0]  HANDLER_PC = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPC_W+ADDR_W-1:0]   mem_rdata,
  input  logic                      irq,
  input  logic                      ie,
  input  logic [ADDR_W-1:0]         ret_pc,
  output phase_e                    phase,
  output logic [OPC_W-1:0]          opc,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      take_irq,
  output logic                      is_ret,
  output logic                      irq_ack
);
  localparam int DATA_W = OPC_W + ADDR_W;

  logic [DATA_W-1:0] ir_q;
  phase_e            nxt;

  assign opc      = ir_q[DATA_W-1 -: OPC_W];
  assign mem_addr = (phase == PH_FETCH) ? pc : ir_q[ADDR_W-1:0];
  assign is_ret   = (phase == PH_EXEC) && (opc == OPC_RETI);
  assign take_irq = (phase == PH_IRQ) && irq && ie;

  always_comb begin
    unique case (phase)
      PH_FETCH: nxt = PH_LATCH;
      PH_LATCH: nxt = PH_EXEC;
      PH_EXEC:  nxt = (opc == OPC_LOAD || opc == OPC_ADD) ? PH_READ : PH_IRQ;
      PH_READ:  nxt = PH_IRQ;
      default:  nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_FETCH;
      pc      <= RESET_PC;
      ir_q    <= '0;
      irq_ack <= 1'b0;
    end else begin
      phase   <= nxt;
      irq_ack <= take_irq;
      if (phase == PH_LATCH) begin
        ir_q <= mem_rdata;
        pc   <= pc + 1'b1;
      end else if (is_ret) begin
        pc   <= ret_pc;
      end else if (take_irq) begin
        pc   <= HANDLER_PC;
      end
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import accp_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 12'hF00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [OPC_W+ADDR_W-1:0] mem_wdata,
  output logic                    mem_we,
  input  logic [OPC_W+ADDR_W-1:0] mem_rdata,
  input  logic                    irq,
  output logic                    irq_ack,
  output logic                    ovf
);
  localparam int DATA_W = OPC_W + ADDR_W;

  phase_e             phase;
  logic [OPC_W-1:0]   opc;
  logic [ADDR_W-1:0]  pc, sv_pc;
  logic [DATA_W-1:0]  acc, sv_acc;
  logic               take_irq, is_ret, ctx_ie;
  logic               ld_en, add_en;

  acc_seq #(
    .ADDR_W     (ADDR_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rdata(mem_rdata),
    .irq      (irq),
    .ie       (ctx_ie),
    .ret_pc   (sv_pc),
    .phase    (phase),
    .opc      (opc),
    .pc       (pc),
    .mem_addr (mem_addr),
    .take_irq (take_irq),
    .is_ret   (is_ret),
    .irq_ack  (irq_ack)
  );

  acc_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take_irq),
    .ret    (is_ret),
    .pc_in  (pc),
    .acc_in (acc),
    .ie     (ctx_ie),
    .sv_pc  (sv_pc),
    .sv_acc (sv_acc)
  );

  assign ld_en  = (phase == PH_READ) && (opc == OPC_LOAD);
  assign add_en = (phase == PH_READ) && (opc == OPC_ADD);

  acc_accu #(.DATA_W(DATA_W)) accu_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .add_en     (add_en),
    .restore_en (is_ret),
    .operand    (mem_rdata),
    .restore_val(sv_acc),
    .acc        (acc),
    .ovf        (ovf)
  );

  assign mem_we    = (phase == PH_EXEC) && (opc == OPC_STORE);
  assign mem_wdata = acc;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 12'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              irq_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ovf,
  input logic              ie
);
  // R9: acknowledge is a single-cycle pulse
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R9: acknowledge coincides with the fetch at the handler address
  a_r9_ack_handler: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (mem_addr == HANDLER_PC));

  // R9: acknowledge only follows a request in the previous cycle
  a_r9_ack_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(irq));

  // R10: a masked request is never acknowledged
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && irq) |=> !irq_ack);

  // R4: a store writes for exactly one cycle
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7: the overflow flag is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .HANDLER_PC(HANDLER_PC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .irq_ack  (irq_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .ovf      (ovf),
  .ie       (ctx_ie)
);

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, irq_ack, ovf;
  logic        irq = 1'b0;

  logic [15:0] mem [0:4095];
  int          ack_cnt = 0;
  int          we_cnt = 0;
  logic [11:0] ack_addr = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  acc_core #(.RESET_PC(12'h300)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .irq(irq), .irq_ack(irq_ack), .ovf(ovf)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (irq_ack) begin
      ack_cnt  <= ack_cnt + 1;
      ack_addr <= mem_addr;
    end
    if (mem_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_mem(int a, logic [15:0] v, int max);
    for (int i = 0; i < max; i++) begin
      if (mem[a] === v) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] ref_add(logic [15:0] a, logic [15:0] b, output bit o);
    int va, vb, s, m;
    va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    s  = va + vb;
    m  = (s < 0) ? -s : s;
    o  = (m > 32767);
    m  = m % 32768;
    return {(s < 0) && (m != 0), m[14:0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [14];
    logic [15:0] exp_v;
    bit          o, any_o;
    int          base_ack, base_we, k;

    // Reset state and example program
    clear_mem();
    mem['h300] = 16'h1940; mem['h301] = 16'h5941; mem['h302] = 16'h2941;
    mem['h303] = 16'h2950;
    mem['h940] = 16'h0003; mem['h941] = 16'h0002;
    do_reset();
    #1;
    chk("R1 addr", {4'h0, mem_addr}, 16'h0300);
    chk("R1 we", {15'b0, mem_we}, 16'h0);
    chk("R1 ack", {15'b0, irq_ack}, 16'h0);
    chk("R1 ovf", {15'b0, ovf}, 16'h0);
    repeat (40) @(negedge clk);
    chk("R12 R3 R5 mem941", mem['h941], 16'h0005);
    chk("R12 R2 fetch at 0x303", mem['h950], 16'h0005);
    chk("R7 no overflow", {15'b0, ovf}, 16'h0);

    // Undefined opcodes
    clear_mem();
    mem['h060] = 16'h0007; mem['h061] = 16'h1234;
    mem['h300] = 16'h1060;
    k = 'h301;
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 2 || op == 5 || op == 15) continue;
      mem[k] = {op[3:0], 12'h061};
      k++;
    end
    mem[k] = 16'h2062;
    do_reset();
    base_we = we_cnt;
    repeat (100) @(negedge clk);
    chk("R8 acc kept", mem['h062], 16'h0007);
    chk("R8 mem kept", mem['h061], 16'h1234);
    chk("R8 write count", 16'(we_cnt - base_we), 16'd1);

    // Sign-magnitude add sweep
    clear_mem();
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h3FFF, 16'h4000, 16'h7FFE, 16'h7FFF,
             16'h8000, 16'h8001, 16'h8002, 16'hBFFF, 16'hC000, 16'hFFFE, 16'hFFFF};
    for (int i = 0; i < 14; i++) mem['h100 + i] = vals[i];
    k = 'h300;
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++) begin
        mem[k]     = 16'h1100 + 16'(i);
        mem[k + 1] = 16'h5100 + 16'(j);
        mem[k + 2] = 16'h2200 + 16'(i * 14 + j);
        k += 3;
      end
    do_reset();
    repeat (3000) @(negedge clk);
    any_o = 0;
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++) begin
        exp_v = ref_add(vals[i], vals[j], o);
        any_o |= o;
        chk((vals[i][15] == vals[j][15]) ? "R5 R4 add same sign" : "R6 R4 add differing sign",
            mem['h200 + i * 14 + j], exp_v);
      end
    chk("R7 overflow sticky", {15'b0, ovf}, {15'b0, any_o});

    // Interrupt entry, masking, return
    clear_mem();
    mem['h080] = 16'h0011; mem['h082] = 16'h0022;
    mem['h300] = 16'h1080;
    mem['h310] = 16'h2081;
    mem['hF00] = 16'h1082; mem['hF01] = 16'h2083; mem['hF02] = 16'hF000;
    do_reset();
    base_ack = ack_cnt;
    repeat (8) @(negedge clk);
    irq = 1'b1;
    wait_mem('h083, 16'h0022, 300);
    irq = 1'b0;
    chk("R9 handler ran", mem['h083], 16'h0022);
    chk("R9 ack address", {4'h0, ack_addr}, 16'h0F00);
    chk("R10 single ack while held", 16'(ack_cnt - base_ack), 16'd1);
    wait_mem('h081, 16'h0011, 300);
    chk("R11 acc restored and resumed", mem['h081], 16'h0011);
    mem['h083] = 16'h0000;
    irq = 1'b1;
    wait_mem('h083, 16'h0022, 300);
    irq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 enable restored", 16'(ack_cnt - base_ack), 16'd2);
    chk("R9 second handler", mem['h083], 16'h0022);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule